// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits on a byte-wide MPEG transport stream and forwards or discards each packet as a whole. It accepts one byte per clock when `in_valid` is high, and `in_sop` marks the first byte of a packet. A packet is 188 bytes long. Its PID is the low five bits of byte 1 joined to all of byte 2. Eight slot registers each hold a PID and an enable flag. Slot 0 also carries three global controls: a pass-everything mode, a block-everything mode and the byte order used for word packing.

The first three bytes of a packet wait in a small queue until the PID is known. After that the packet either streams out byte by byte or disappears. A packer after the gate groups every four forwarded bytes of a packet into a 32-bit word. Register writes land in a shadow copy that can be read back at once. The copy the filter uses is refreshed only when a new packet starts, so a packet is judged against one consistent setting.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset, register 0 reads 0x00003FFF (block-everything set, slot disabled, PID 0x1FFF). Registers 1 to 7 read 0x00001FFF. No byte or word is output.
- R2: A register reads back the written value masked to its implemented bits. Register 0 keeps bits 16:0: bit 16 pass-all, bit 15 enable, bit 14 byte order, bit 13 block-all, bits 12:0 PID. Registers 1 to 7 keep bits 15 and 12:0 (mask 0x9FFF).
- R3: When an enabled slot's PID equals the packet PID ({byte1[4:0], byte2}), all 188 bytes are output in order. `out_sop` is high on the first output byte only.
- R4: A packet whose PID matches no enabled slot produces no output. A disabled slot holding the same PID does not match.
- R5: With pass-all (register 0 bit 16) set, every packet with a valid sync byte is forwarded, even when block-all is also set.
- R6: With block-all (register 0 bit 13) set and pass-all clear, every packet is dropped, even one whose PID matches an enabled slot.
- R7: A packet whose first byte is not 0x47 is dropped in every mode.
- R8: A register write made while a packet is being received does not change how that packet is handled. It applies from the next packet start.
- R9: Each group of four forwarded bytes of a packet, counted from its first byte, appears on `out_word` one cycle after the fourth byte. With register 0 bit 14 set, the first byte of the group sits in bits 7:0. With bit 14 clear, it sits in bits 31:24. The setting in force at the packet start applies.
- R10: Valid bytes arriving after the 188th byte of a packet and before the next start-of-packet are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_data | input | 8 | Input stream byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (slot number) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the addressed shadow register |
| out_valid | output | 1 | Output byte strobe |
| out_sop | output | 1 | Output byte is the first of a forwarded packet |
| out_data | output | 8 | Output stream byte |
| out_word_valid | output | 1 | Packed word strobe |
| out_word | output | 32 | Four forwarded bytes packed in the selected order |

## Verification
Several checks run on every cycle. The first byte of any forwarded packet must be the sync value. No forwarded run may exceed one packet without a new start. The holding queue never fills. The applied register copy changes only on a packet start, and a packed word only follows an output byte.

The bench's scenarios must show the rest: which packets pass under each mode combination, that a disabled slot or a bad sync suppresses output, and how a write in mid-packet is deferred. They must also show that stray bytes after the 188th are discarded and that both byte orders pack correctly. Each of these is compared byte by byte and word by word against a behavioural model.

// File: rtl/ts_filt_pkg.sv
// Shared types and constants for the transport stream PID filter.
package ts_filt_pkg;
    localparam int          PID_W     = 13;
    localparam logic [7:0]  SYNC_BYTE = 8'h47;
    localparam int          BIT_NOFIL = 16;
    localparam int          BIT_EN    = 15;
    localparam int          BIT_LE    = 14;
    localparam int          BIT_ALL   = 13;

    typedef struct packed {
        logic             en;
        logic [PID_W-1:0] pid;
    } slot_t;

    typedef struct packed {
        logic nofil;
        logic le;
        logic allfil;
    } mode_t;
endpackage

// File: rtl/tsf_regs.sv
// Slot registers: a shadow copy that software writes and reads back, and an
// applied copy that the filter uses. The applied copy is reloaded only when
// commit is high, which is the start of a packet.
// Assumes NSLOT <= 2**ADDR_W.
module tsf_regs
    import ts_filt_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic                commit,
    output slot_t [NSLOT-1:0]   act_slot,
    output mode_t               act_mode
);
    slot_t [NSLOT-1:0] sh_slot;
    mode_t             sh_mode;
    logic              unused_hi;

    assign unused_hi = ^wdata[31:17];

    // Shadow registers take software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) sh_slot[i] <= '{en: 1'b0, pid: '1};
            sh_mode <= '{nofil: 1'b0, le: 1'b0, allfil: 1'b1};
        end else if (we) begin
            sh_slot[addr] <= '{en: wdata[BIT_EN], pid: wdata[PID_W-1:0]};
            if (addr == '0)
                sh_mode <= '{nofil: wdata[BIT_NOFIL], le: wdata[BIT_LE], allfil: wdata[BIT_ALL]};
        end
    end

    // Applied copy follows the shadow only at a packet start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) act_slot[i] <= '{en: 1'b0, pid: '1};
            act_mode <= '{nofil: 1'b0, le: 1'b0, allfil: 1'b1};
        end else if (commit) begin
            act_slot <= sh_slot;
            act_mode <= sh_mode;
        end
    end

    // Read-back of the addressed shadow register.
    always_comb begin
        rdata = '0;
        rdata[PID_W-1:0] = sh_slot[addr].pid;
        rdata[BIT_EN]    = sh_slot[addr].en;
        if (addr == '0) begin
            rdata[BIT_NOFIL] = sh_mode.nofil;
            rdata[BIT_LE]    = sh_mode.le;
            rdata[BIT_ALL]   = sh_mode.allfil;
        end
    end

    p_hold_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_slot) && $stable(act_mode)));
endmodule

// File: rtl/tsf_match.sv
// Parallel PID compare: hit is high when any enabled slot holds pid.
// Purely combinational, so no clock is needed.
module tsf_match
    import ts_filt_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  slot_t [NSLOT-1:0]  slot,
    input  logic [PID_W-1:0]   pid,
    output logic               hit
);
    logic [NSLOT-1:0] slot_hit;

    // One comparator for each slot.
    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign slot_hit[g] = slot[g].en && (slot[g].pid == pid);
    end

    assign hit = |slot_hit;
endmodule

// File: rtl/tsf_gate.sv
// Packet framing, header capture, keep/drop decision and the holding queue.
// Each byte goes into a small queue tagged with its packet. A packet's bytes
// leave the queue once that packet has been judged, which happens at its third
// byte. Assumes PKT_LEN >= 3, DEPTH is a power of two and DEPTH >= 4.
module tsf_gate
    import ts_filt_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int DEPTH   = 4,
    parameter int TAG_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_data,
    output logic [PID_W-1:0]  pid,
    input  logic              hit,
    input  mode_t             mode,
    output logic              out_valid,
    output logic              out_sop,
    output logic [7:0]        out_data,
    output logic              out_le
);
    localparam int NTAG  = 1 << TAG_W;
    localparam int PTR_W = $clog2(DEPTH);
    localparam int IDX_W = $clog2(PKT_LEN + 1);

    logic [IDX_W-1:0] idx;
    logic             in_pkt;
    logic             accept;
    logic             sync_ok;
    logic [4:0]       hdr1;
    logic             decide;
    logic [TAG_W-1:0] cur_tag, nxt_tag;
    logic [NTAG-1:0]  dec_done, keep, le_of;

    logic [7:0]       f_data [DEPTH];
    logic             f_sop  [DEPTH];
    logic [TAG_W-1:0] f_tag  [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   cnt;
    logic             pop;

    assign accept  = in_valid && (in_sop || in_pkt);
    assign nxt_tag = cur_tag + 1'b1;
    assign pid     = {hdr1, in_data};
    assign decide  = sync_ok && (mode.nofil || (!mode.allfil && hit));
    assign pop     = (cnt != '0) && dec_done[f_tag[rd_ptr]];

    // Byte position within the packet; bytes past the last one are refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            in_pkt <= 1'b0;
        end else if (in_valid && in_sop) begin
            idx    <= IDX_W'(1);
            in_pkt <= 1'b1;
        end else if (in_valid && in_pkt) begin
            idx <= idx + 1'b1;
            if (idx == IDX_W'(PKT_LEN - 1)) in_pkt <= 1'b0;
        end
    end

    // Capture the sync check and the upper PID bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_ok <= 1'b0;
            hdr1    <= '0;
        end else if (accept && in_sop) begin
            sync_ok <= (in_data == SYNC_BYTE);
        end else if (accept && idx == IDX_W'(1)) begin
            hdr1 <= in_data[4:0];
        end
    end

    // Verdict for each packet tag; a packet cut short before its third byte is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_tag  <= '0;
            dec_done <= '1;
            keep     <= '0;
            le_of    <= '0;
        end else if (accept && in_sop) begin
            if (!dec_done[cur_tag]) begin
                dec_done[cur_tag] <= 1'b1;
                keep[cur_tag]     <= 1'b0;
            end
            dec_done[nxt_tag] <= 1'b0;
            cur_tag           <= nxt_tag;
        end else if (accept && idx == IDX_W'(2)) begin
            dec_done[cur_tag] <= 1'b1;
            keep[cur_tag]     <= decide;
            le_of[cur_tag]    <= mode.le;
        end
    end

    // Queue storage.
    always_ff @(posedge clk) begin
        if (accept) begin
            f_data[wr_ptr] <= in_data;
            f_sop[wr_ptr]  <= in_sop;
            f_tag[wr_ptr]  <= in_sop ? nxt_tag : cur_tag;
        end
    end

    // Queue pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (pop)    rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + (PTR_W+1)'(accept) - (PTR_W+1)'(pop);
        end
    end

    // Output register: a judged byte leaves the queue and is emitted if its packet is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_data  <= '0;
            out_le    <= 1'b0;
        end else begin
            out_valid <= pop && keep[f_tag[rd_ptr]];
            out_sop   <= pop && f_sop[rd_ptr];
            out_data  <= f_data[rd_ptr];
            out_le    <= le_of[f_tag[rd_ptr]];
        end
    end

    // Checker: length of the current forwarded run.
    logic [IDX_W-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)         run_cnt <= '0;
        else if (out_valid) run_cnt <= out_sop ? IDX_W'(1) : run_cnt + 1'b1;
    end

    p_fifo_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < (PTR_W+1)'(DEPTH));
    p_run_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop) |-> (run_cnt != '0 && run_cnt < IDX_W'(PKT_LEN)));
    p_lead_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> (out_data == SYNC_BYTE));
endmodule

// File: rtl/tsf_packer.sv
// Groups the forwarded bytes of a packet into words of BYTES bytes, counting
// from the packet's first byte. The byte order follows byte_le. Assumes the
// packet length is a multiple of BYTES.
module tsf_packer #(
    parameter int BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_valid,
    input  logic               byte_sop,
    input  logic [7:0]         byte_data,
    input  logic               byte_le,
    output logic               word_valid,
    output logic [8*BYTES-1:0] word
);
    localparam int LANE_W = $clog2(BYTES);

    logic [LANE_W-1:0]  lane, lane_nx, pos;
    logic [8*BYTES-1:0] acc, acc_nx;

    // Place the incoming byte in its lane.
    always_comb begin
        lane_nx = byte_sop ? '0 : lane + 1'b1;
        pos     = byte_le ? lane_nx : LANE_W'(BYTES - 1) - lane_nx;
        acc_nx  = acc;
        acc_nx[8*pos +: 8] = byte_data;
    end

    // Accumulate lanes and release a word when the last lane fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane       <= '0;
            acc        <= '0;
            word       <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (byte_valid) begin
                lane <= lane_nx;
                acc  <= acc_nx;
                if (lane_nx == LANE_W'(BYTES - 1)) begin
                    word       <= acc_nx;
                    word_valid <= 1'b1;
                end
            end
        end
    end

    p_word_follows_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(byte_valid));
endmodule

// File: rtl/ts_pid_filter.sv
// Transport stream PID filter top. It joins the slot registers, the matcher,
// the packet gate and the word packer. The applied register copy is refreshed
// on each accepted start-of-packet byte.
module ts_pid_filter #(
    parameter int NSLOT   = 8,
    parameter int ADDR_W  = 3,
    parameter int PKT_LEN = 188,
    parameter int DEPTH   = 4,
    parameter int TAG_W   = 2,
    parameter int BYTES   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic [7:0]         in_data,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               out_valid,
    output logic               out_sop,
    output logic [7:0]         out_data,
    output logic               out_word_valid,
    output logic [8*BYTES-1:0] out_word
);
    import ts_filt_pkg::*;

    slot_t [NSLOT-1:0] act_slot;
    mode_t             act_mode;
    logic [PID_W-1:0]  pid;
    logic              hit;
    logic              out_le;

    tsf_regs #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .commit(in_valid && in_sop),
        .act_slot(act_slot), .act_mode(act_mode)
    );

    tsf_match #(.NSLOT(NSLOT)) u_match (
        .slot(act_slot), .pid(pid), .hit(hit)
    );

    tsf_gate #(.PKT_LEN(PKT_LEN), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .pid(pid), .hit(hit), .mode(act_mode),
        .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
        .out_le(out_le)
    );

    tsf_packer #(.BYTES(BYTES)) u_pack (
        .clk(clk), .rst_n(rst_n), .byte_valid(out_valid), .byte_sop(out_sop),
        .byte_data(out_data), .byte_le(out_le),
        .word_valid(out_word_valid), .word(out_word)
    );
endmodule

// File: tb/sim_ts_pid_filter.sv
`timescale 1ns/1ps
module sim_ts_pid_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        out_valid, out_sop, out_word_valid;
    logic [7:0]  out_data;
    logic [31:0] out_word;

    int compared = 0, mismatched = 0, cycles = 0, pkt_no = 0;
    bit finished = 0;
    logic [31:0] shadow [8];
    logic [8:0]  exp_b [$];
    logic [31:0] exp_w [$];

    always #2.5 clk = ~clk;

    ts_pid_filter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_valid(out_valid),
        .out_sop(out_sop), .out_data(out_data), .out_word_valid(out_word_valid),
        .out_word(out_word)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Watchdog: a hung run is one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cycles);
            summary();
            $finish;
        end
    end

    // Every-clock comparison of outputs against the model queues (R3, R9).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            compared++;
            if (exp_b.size() == 0) begin
                mismatched++;
                $display("FAIL R3/R4: unexpected byte actual %02h sop %0b, expected none", out_data, out_sop);
            end else begin
                logic [8:0] e;
                e = exp_b.pop_front();
                if ({out_sop, out_data} !== e) begin
                    mismatched++;
                    $display("FAIL R3: byte actual sop%0b %02h expected sop%0b %02h", out_sop, out_data, e[8], e[7:0]);
                end
            end
        end
        if (rst_n && out_word_valid) begin
            compared++;
            if (exp_w.size() == 0) begin
                mismatched++;
                $display("FAIL R9: unexpected word actual %08h, expected none", out_word);
            end else begin
                logic [31:0] w;
                w = exp_w.pop_front();
                if (out_word !== w) begin
                    mismatched++;
                    $display("FAIL R9: word actual %08h expected %08h", out_word, w);
                end
            end
        end
    end

    function automatic logic [31:0] rmask(input int a, input logic [31:0] v);
        return (a == 0) ? (v & 32'h0001FFFF) : (v & 32'h00009FFF);
    endfunction

    function automatic bit model_keep(input logic [12:0] pid, input logic [7:0] sync,
                                      input logic [31:0] img [8]);
        if (sync != 8'h47) return 0;
        if (img[0][16]) return 1;
        if (img[0][13]) return 0;
        for (int i = 0; i < 8; i++)
            if (img[i][15] && img[i][12:0] == pid) return 1;
        return 0;
    endfunction

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; reg_we = 1'b0;
        end
    endtask

    task automatic write_reg(input int a, input logic [31:0] v);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = v;
        shadow[a] = rmask(a, v);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic read_check(input int a, input logic [31:0] e, input string req);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; reg_we = 1'b0; reg_addr = 3'(a);
        #1;
        compared++;
        if (reg_rdata !== e) begin
            mismatched++;
            $display("FAIL %s: reg %0d actual %08h expected %08h", req, a, reg_rdata, e);
        end
    endtask

    task automatic drain(input string req);
        idle(12);
        @(negedge clk);
        #1;
        compared++;
        if (exp_b.size() != 0 || exp_w.size() != 0) begin
            mismatched++;
            $display("FAIL %s: outstanding bytes actual %0d words %0d, expected 0 and 0",
                     req, exp_b.size(), exp_w.size());
        end
        exp_b.delete();
        exp_w.delete();
    endtask

    // Drive one packet. Optionally idle every fifth byte and write a register at byte 50.
    task automatic send(input logic [12:0] pid, input logic [7:0] sync, input bit gaps,
                        input int mid_a, input logic [31:0] mid_v);
        logic [7:0]  b [188];
        logic [31:0] img [8];
        bit          k;
        b[0] = sync;
        b[1] = {3'b010, pid[12:8]};
        b[2] = pid[7:0];
        for (int i = 3; i < 188; i++) b[i] = 8'((pkt_no * 7 + i * 3) & 8'hFF);
        pkt_no++;
        for (int i = 0; i < 8; i++) img[i] = shadow[i];
        k = model_keep(pid, sync, img);
        if (k) begin
            for (int i = 0; i < 188; i++) exp_b.push_back({(i == 0), b[i]});
            for (int w = 0; w < 47; w++)
                exp_w.push_back(img[0][14] ? {b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]}
                                           : {b[4*w], b[4*w+1], b[4*w+2], b[4*w+3]});
        end
        for (int i = 0; i < 188; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = (i == 0); in_data = b[i];
            reg_we = (mid_a >= 0 && i == 50);
            if (mid_a >= 0 && i == 50) begin
                reg_addr = 3'(mid_a); reg_wdata = mid_v;
                shadow[mid_a] = rmask(mid_a, mid_v);
            end
            if (gaps && (i % 5 == 4) && i != 187) begin
                @(negedge clk);
                in_valid = 1'b0; in_sop = 1'b0; reg_we = 1'b0;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) shadow[i] = (i == 0) ? 32'h00003FFF : 32'h00001FFF;
        idle(4);
        rst_n = 1'b1;
        // R1: reset values and silence.
        for (int a = 0; a < 8; a++) read_check(a, (a == 0) ? 32'h00003FFF : 32'h00001FFF, "R1");
        drain("R1");
        // R6: block-all is set out of reset.
        send(13'h100, 8'h47, 0, -1, 0);
        drain("R6");
        // R2: read-back masking.
        write_reg(0, 32'h0000C100);
        write_reg(3, 32'h00009ABC);
        write_reg(5, 32'hFFFFFFFF);
        read_check(5, 32'h00009FFF, "R2");
        read_check(0, 32'h0000C100, "R2");
        read_check(3, 32'h00009ABC, "R2");
        write_reg(5, 32'h00001FFF);
        write_reg(4, 32'h00000055);
        // R3: matches on two slots, back to back, then with gaps.
        send(13'h100, 8'h47, 0, -1, 0);
        send(13'h1ABC, 8'h47, 0, -1, 0);
        send(13'h1ABC, 8'h47, 1, -1, 0);
        drain("R3");
        // R4: PID only in a disabled slot, between two forwarded packets.
        send(13'h100, 8'h47, 0, -1, 0);
        send(13'h0055, 8'h47, 0, -1, 0);
        send(13'h0123, 8'h47, 1, -1, 0);
        send(13'h100, 8'h47, 0, -1, 0);
        drain("R4");
        // R7: bad sync on a matching PID.
        send(13'h100, 8'h46, 0, -1, 0);
        drain("R7");
        // R5: pass-all overrides block-all; a bad sync is still dropped (R7).
        write_reg(0, 32'h00016000);
        send(13'h0777, 8'h47, 0, -1, 0);
        send(13'h0777, 8'h00, 0, -1, 0);
        send(13'h1FFF, 8'h47, 1, -1, 0);
        drain("R5");
        // R6: block-all beats a match.
        write_reg(0, 32'h0000A100);
        send(13'h100, 8'h47, 0, -1, 0);
        drain("R6");
        // R9: the other byte order.
        write_reg(0, 32'h00008100);
        send(13'h100, 8'h47, 1, -1, 0);
        drain("R9");
        // R8: writes in mid-packet are deferred to the next start.
        send(13'h100, 8'h47, 0, 0, 32'h00002000);
        send(13'h100, 8'h47, 0, -1, 0);
        drain("R8");
        send(13'h100, 8'h47, 0, 0, 32'h00008100);
        send(13'h100, 8'h47, 0, -1, 0);
        drain("R8");
        // R10: stray bytes after a full packet are discarded.
        write_reg(0, 32'h00010000);
        send(13'h0200, 8'h47, 0, -1, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_data = (i == 0) ? 8'h47 : 8'(i);
        end
        idle(3);
        send(13'h0201, 8'h47, 0, -1, 0);
        drain("R10");
        finished = 1;
        summary();
        $finish;
    end
endmodule